// File: doc/BRIEF.md
# Escape-Time Fractal Pixel Engine

This block works out the escape-time value of a single pixel of a Mandelbrot or Julia image. A caller presents a complex constant, an optional starting point and a mode bit with a one-cycle start pulse. The block then repeats z = z*z + c on signed fixed-point numbers. It stops when the squared magnitude of z reaches 4.0 or when the iteration limit is reached. It then pulses done and presents the iteration count together with a flag that says whether the point escaped. The count selects the pixel colour. A point that never escapes is drawn black.

Each iteration needs three products: x*x, y*y and x*y. All three run in turn on one sequential radix-2 Booth multiplier, which retires one multiplier bit per clock. A small state machine steps through the three products and then runs the escape test. Mapping screen positions to coordinates, the palette and the video timing sit outside this block.

Top module: `mandel_engine`

## Requirements
- R1: Synchronous active-high reset leaves `done` and `escaped` low and `iter_count` at zero.
- R2: With `julia` low (Mandelbrot mode), z starts at 0 and c is (`c_re`, `c_im`). The values on `z_re0` and `z_im0` have no effect on the result.
- R3: With `julia` high, z starts at (`z_re0`, `z_im0`) and c is (`c_re`, `c_im`), held constant for the whole pixel.
- R4: All values are W-bit two's complement with IBITS integer bits (sign included), which is Q4.20 by default. Products are shifted arithmetically right by FRAC (floor), and by FRAC-1 for 2xy. Each product is then saturated to W bits. The update is x' = sat(x² − y² + cx) and y' = sat(2xy + cy), both saturated to W bits.
- R5: Before each update the block tests x² + y² ≥ 4.0, using the saturated squares. If the test holds, `escaped` is 1 and `iter_count` is the number of updates already applied. This covers exactly 4.0 and a count of 0.
- R6: If the test at count MAX_ITER fails, the result is `escaped` = 0 and `iter_count` = MAX_ITER. When the escape test and the limit fall on the same test, the escape wins.
- R7: `done` is a one-cycle pulse. It rises exactly (n+1)·(3W+7) clock edges after the edge that accepts `start`, where n is the reported count.
- R8: A `start` pulse that arrives while a pixel is in progress is ignored, and the running pixel finishes with its original operands.
- R9: `iter_count` and `escaped` hold their values between `done` pulses.
- R10: A `start` given in the same cycle as `done` is accepted, so pixels can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a pixel |
| julia | input | 1 | 1 = Julia mode, 0 = Mandelbrot mode |
| c_re | input | W | Real part of c, signed fixed point |
| c_im | input | W | Imaginary part of c, signed fixed point |
| z_re0 | input | W | Real part of the initial z (Julia mode) |
| z_im0 | input | W | Imaginary part of the initial z (Julia mode) |
| done | output | 1 | Result-valid pulse |
| escaped | output | 1 | 1 if the point escaped before the limit |
| iter_count | output | $clog2(MAX_ITER+1) | Escape-time count |

## Verification
The escape test and the iteration limit can fire on the same test. The bench provokes this with a reference-driven search along the real axis just above 0.25. The search looks for a constant whose first escaping test falls exactly on count MAX_ITER. For that constant the bench expects an escape reported with count MAX_ITER, not a black pixel. A second coincidence is tested the same way: a new start arriving in the very cycle that `done` pulses. This start must be taken, while a start pulse injected in mid-computation must leave the running result unchanged.

// File: rtl/mandel_pkg.sv
package mandel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XX,
    ST_YY,
    ST_XY,
    ST_TEST
  } mstate_t;
endpackage

// File: rtl/mandel_fx_sat.sv
module mandel_fx_sat #(
  parameter int IN_W  = 48,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic all_one, all_zero;

  // in range when every bit above the kept sign matches the sign
  assign all_one  = &din[IN_W-1:OUT_W-1];
  assign all_zero = ~|din[IN_W-1:OUT_W-1];

  always_comb begin
    if (all_one || all_zero) dout = din[OUT_W-1:0];
    else if (din[IN_W-1])    dout = MINV;
    else                     dout = MAXV;
  end
endmodule

// File: rtl/mandel_booth_mul.sv
module mandel_booth_mul #(
  parameter int W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  output logic                  done,
  output logic signed [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic signed [W:0] acc, mcand, sum;
  logic [W-1:0]      mq;
  logic              qm1;
  logic [CW-1:0]     cnt;
  logic              busy;

  // radix-2 Booth recoding of the current multiplier bit pair
  always_comb begin
    case ({mq[0], qm1})
      2'b01:   sum = acc + mcand;
      2'b10:   sum = acc - mcand;
      default: sum = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      mcand <= '0;
      mq    <= '0;
      qm1   <= 1'b0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc   <= '0;
        mcand <= (W+1)'(a);
        mq    <= b;
        qm1   <= 1'b0;
        cnt   <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        acc <= {sum[W], sum[W:1]};
        mq  <= {sum[0], mq[W-1:1]};
        qm1 <= mq[0];
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = {acc[W-1:0], mq};

  // R7: the controller only launches a multiply into an idle unit
  p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R7: completion is a single-cycle pulse
  p_mul_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mandel_engine.sv
module mandel_engine
  import mandel_pkg::*;
#(
  parameter int W        = 24,
  parameter int IBITS    = 4,
  parameter int MAX_ITER = 256,
  localparam int CNT_W   = $clog2(MAX_ITER + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                julia,
  input  logic signed [W-1:0] c_re,
  input  logic signed [W-1:0] c_im,
  input  logic signed [W-1:0] z_re0,
  input  logic signed [W-1:0] z_im0,
  output logic                done,
  output logic                escaped,
  output logic [CNT_W-1:0]    iter_count
);
  localparam int FRAC = W - IBITS;
  localparam logic [W:0] FOUR = (W+1)'(1) << (FRAC + 2);

  mstate_t st;
  logic signed [W-1:0] x_q, y_q, cr_q, ci_q, xx_q, yy_q, xy_q;
  logic [CNT_W-1:0]    n_q;
  logic                mul_go, mul_done;
  logic signed [W-1:0] op_a, op_b;
  logic signed [2*W-1:0] mul_prod, sc_one, sc_two;
  logic signed [W-1:0] p_sat, p2_sat, nx_sat, ny_sat;
  logic signed [W+1:0] nx_sum;
  logic signed [W:0]   ny_sum;
  logic [W:0]          mag;
  logic                mag_ge4;

  // operand routing for the three products of one iteration
  assign op_a = (st == ST_YY) ? y_q : x_q;
  assign op_b = (st == ST_XX) ? x_q : y_q;

  mandel_booth_mul #(.W(W)) u_mul (
    .clk   (clk),
    .rst   (rst),
    .start (mul_go),
    .a     (op_a),
    .b     (op_b),
    .done  (mul_done),
    .prod  (mul_prod)
  );

  assign sc_one = mul_prod >>> FRAC;
  assign sc_two = mul_prod >>> (FRAC - 1);

  mandel_fx_sat #(.IN_W(2*W), .OUT_W(W)) u_sat_sq (.din(sc_one), .dout(p_sat));
  mandel_fx_sat #(.IN_W(2*W), .OUT_W(W)) u_sat_xy (.din(sc_two), .dout(p2_sat));

  assign nx_sum = (W+2)'(xx_q) - (W+2)'(yy_q) + (W+2)'(cr_q);
  assign ny_sum = (W+1)'(xy_q) + (W+1)'(ci_q);

  mandel_fx_sat #(.IN_W(W+2), .OUT_W(W)) u_sat_nx (.din(nx_sum), .dout(nx_sat));
  mandel_fx_sat #(.IN_W(W+1), .OUT_W(W)) u_sat_ny (.din(ny_sum), .dout(ny_sat));

  assign mag     = {1'b0, xx_q} + {1'b0, yy_q};
  assign mag_ge4 = (mag >= FOUR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      x_q        <= '0;
      y_q        <= '0;
      cr_q       <= '0;
      ci_q       <= '0;
      xx_q       <= '0;
      yy_q       <= '0;
      xy_q       <= '0;
      n_q        <= '0;
      mul_go     <= 1'b0;
      done       <= 1'b0;
      escaped    <= 1'b0;
      iter_count <= '0;
    end else begin
      mul_go <= 1'b0;
      done   <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          cr_q   <= c_re;
          ci_q   <= c_im;
          x_q    <= julia ? z_re0 : '0;
          y_q    <= julia ? z_im0 : '0;
          n_q    <= '0;
          st     <= ST_XX;
          mul_go <= 1'b1;
        end
        ST_XX: if (mul_done) begin
          xx_q   <= p_sat;
          st     <= ST_YY;
          mul_go <= 1'b1;
        end
        ST_YY: if (mul_done) begin
          yy_q   <= p_sat;
          st     <= ST_XY;
          mul_go <= 1'b1;
        end
        ST_XY: if (mul_done) begin
          xy_q <= p2_sat;
          st   <= ST_TEST;
        end
        ST_TEST: begin
          if (mag_ge4) begin
            done       <= 1'b1;
            escaped    <= 1'b1;
            iter_count <= n_q;
            st         <= ST_IDLE;
          end else if (n_q == CNT_W'(MAX_ITER)) begin
            done       <= 1'b1;
            escaped    <= 1'b0;
            iter_count <= n_q;
            st         <= ST_IDLE;
          end else begin
            x_q    <= nx_sat;
            y_q    <= ny_sat;
            n_q    <= n_q + 1'b1;
            st     <= ST_XX;
            mul_go <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: result strobe lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: results change only together with the strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(iter_count) && $stable(escaped)));
  // R6: a non-escaping result always carries the limit
  p_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !escaped) |-> (iter_count == CNT_W'(MAX_ITER)));
  // R5: reported counts never pass the limit
  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (iter_count <= CNT_W'(MAX_ITER)));
  // R8: a start during a running pixel leaves its constant untouched
  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && start) |=> ($stable(cr_q) && $stable(ci_q)));
  // R4: the squares reaching the test are never negative
  p_sq_pos_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TEST) |-> (!xx_q[W-1] && !yy_q[W-1]));
endmodule

// File: tb/mandel_engine_test.sv
module mandel_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 24;
  localparam int IB   = 4;
  localparam int FR   = W - IB;
  localparam int MAXI = 12;
  localparam int CW   = $clog2(MAXI + 1);
  localparam int PER  = 3 * W + 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic julia = 1'b0;
  logic signed [W-1:0] c_re = '0, c_im = '0, z_re0 = '0, z_im0 = '0;
  logic done, escaped;
  logic [CW-1:0] iter_count;

  int total = 0;
  int bad = 0;
  int last_n = 0;
  bit last_e = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mandel_engine #(.W(W), .IBITS(IB), .MAX_ITER(MAXI)) uut (
    .clk(clk), .rst(rst), .start(start), .julia(julia),
    .c_re(c_re), .c_im(c_im), .z_re0(z_re0), .z_im0(z_im0),
    .done(done), .escaped(escaped), .iter_count(iter_count)
  );

  function automatic longint satw(longint v);
    longint hi = (longint'(1) <<< (W-1)) - 1;
    longint lo = -(longint'(1) <<< (W-1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint fmul(longint a, longint b, int sh);
    return satw((a * b) >>> sh);
  endfunction

  function automatic longint fx(real r);
    return longint'($rtoi(r * (2.0 ** FR)));
  endfunction

  // behavioural escape-time reference
  function automatic void ref_px(input longint cr, input longint ci,
                                 input longint zr, input longint zi,
                                 input bit jul, output int n, output bit e);
    longint x, y, xx, yy, xy2;
    x = jul ? zr : 0;
    y = jul ? zi : 0;
    n = 0;
    e = 1'b0;
    forever begin
      xx  = fmul(x, x, FR);
      yy  = fmul(y, y, FR);
      xy2 = fmul(x, y, FR - 1);
      if (xx + yy >= (longint'(4) <<< FR)) begin e = 1'b1; return; end
      if (n == MAXI) begin e = 1'b0; return; end
      x = satw(xx - yy + cr);
      y = satw(xy2 + ci);
      n++;
    end
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one pixel at a falling edge and compare every cycle until done
  task automatic run(longint cr, longint ci, longint zr, longint zi,
                     bit jul, string req, bit poke);
    int n, lat;
    bit e;
    ref_px(satw(cr), satw(ci), satw(zr), satw(zi), jul, n, e);
    lat = (n + 1) * PER;
    c_re = W'(cr); c_im = W'(ci); z_re0 = W'(zr); z_im0 = W'(zi);
    julia = jul;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= lat; i++) begin
      if (i > 0) @(negedge clk);
      check(done == (i == lat), "R7", "done", longint'(done), longint'(i == lat));
      if (poke && i == 3) begin
        // R8 stimulus: foreign request mid-pixel
        start = 1'b1; julia = ~jul;
        c_re = W'(fx(-1.9)); c_im = W'(fx(1.1));
        z_re0 = W'(fx(0.7)); z_im0 = W'(fx(-0.4));
      end
      if (poke && i == 4) start = 1'b0;
    end
    check(iter_count == CW'(n), req, "count", longint'(iter_count), longint'(n));
    check(escaped == e, req, "escaped", longint'(escaped), longint'(e));
    last_n = n;
    last_e = e;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check(done == 1'b0, "R9", "done", longint'(done), 0);
      check(iter_count == CW'(last_n), "R9", "held count", longint'(iter_count), longint'(last_n));
      check(escaped == last_e, "R9", "held escaped", longint'(escaped), longint'(last_e));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint found;
    int fn;
    bit fe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done", longint'(done), 0);
    check(escaped == 1'b0, "R1", "escaped", longint'(escaped), 0);
    check(iter_count == '0, "R1", "count", longint'(iter_count), 0);

    // R6: origin never escapes
    run(0, 0, 0, 0, 1'b0, "R6", 1'b0);
    // R5: |c| = 2 exactly escapes after one update
    run(fx(2.0), 0, 0, 0, 1'b0, "R5", 1'b0);
    // R2: starting point ignored in Mandelbrot mode
    run(fx(-1.0), fx(0.3), fx(3.0), fx(-2.5), 1'b0, "R2", 1'b0);
    // R3/R5: Julia start already on the circle gives count 0
    run(fx(-0.8), fx(0.156), fx(2.0), 0, 1'b1, "R3", 1'b0);
    // R4: saturating extremes
    run(-(longint'(1) <<< (W-1)), (longint'(1) <<< (W-1)) - 1, 0, 0, 1'b0, "R4", 1'b0);
    run(fx(0.3), fx(-0.2), -(longint'(1) <<< (W-1)), -(longint'(1) <<< (W-1)), 1'b1, "R4", 1'b0);
    run(fx(-1.75), fx(0.0), 0, 0, 1'b0, "R4", 1'b0);

    // R6 priority: escape found on the very test at the limit
    found = -1;
    for (int k = 1; k < 8000 && found < 0; k++) begin
      ref_px(fx(0.25) + longint'(k) * 256, 0, 0, 0, 1'b0, fn, fe);
      if (fn == MAXI && fe) found = fx(0.25) + longint'(k) * 256;
    end
    check(found >= 0, "R6", "priority point found", found >= 0, 1);
    if (found >= 0) run(found, 0, 0, 0, 1'b0, "R6", 1'b0);

    // R8: start during computation ignored
    run(fx(-0.5), fx(0.5), 0, 0, 1'b0, "R8", 1'b1);
    idle(6);

    // R10: back-to-back Mandelbrot grid, R4 arithmetic
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 6; j++)
        run(fx(-2.5 + 0.5 * i), fx(-1.25 + 0.5 * j), 0, 0, 1'b0, "R10", 1'b0);
    idle(3);
    // R3: Julia grid with a fixed constant
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        run(fx(-0.8), fx(0.156), fx(-1.5 + 1.0 * i), fx(-1.5 + 1.0 * j), 1'b1, "R3", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule